// File: doc/BRIEF.md
# Keypad Password Door Lock Controller

This block is a synchronous state machine that guards a door with a fixed sequence of key presses from a two-key keypad (keys "A" and "B"). Each clock cycle it looks at a key-active flag and the two key lines. A press is counted once, on the cycle where the key-active flag rises. The block drives a 4-bit press count for an LED digit decoder and a one-cycle unlock pulse.

A wrong key does not abort the entry. The machine moves onto a parallel path of failed states at the same depth. That path keeps counting presses and never unlocks, so the user learns of a failure only after the full sequence has been entered. One cycle after the final press, both the success state and the failure state return to the start state.

The length and the content of the sequence are parameters. The default is B, then A, then B. The keypad signals are expected to be synchronous to the clock already.

Top module: `keylock_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) puts the machine in the start state. After that edge `press_count` is 0 and `unlock` is 0.
- R2: Key codes are read as {`key_k`,`key_a`,`key_b`}. 110 is key A and 101 is key B. Any other code with `key_k`=1 (100 or 111) is a wrong key. With `key_k`=0 no key is present and `key_a`/`key_b` are ignored.
- R3: A press is counted only on a cycle where `key_k` is 1 and was 0 in the previous cycle. A key held for many cycles counts once. With no new press the state and outputs stay the same, except at full depth.
- R4: `press_count` equals the number of presses accepted since the machine last left the start state: 0, 1, 2 or 3. The count rises by one in the cycle after each accepted press, on both the correct path and the failed path.
- R5: The password parameter has bit i = 1 for key B and 0 for key A, with bit 0 entered first. The default 3'b101 means B, A, B. After the last correct press, `unlock` is 1 for the next cycle and `press_count` is 3 in that cycle.
- R6: A press that does not match the expected key, or that comes after an earlier mismatch, still advances the count. That entry then never raises `unlock`, even when it reaches count 3.
- R7: In the cycle after the count reaches 3, whether on the correct or the failed path, the machine returns to count 0 whatever the inputs are. A press made in that cycle is dropped.
- R8: `unlock` is never high in two consecutive cycles. It pulses exactly once for each correct sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| key_k | input | 1 | Key-active flag from the keypad |
| key_a | input | 1 | Key A line |
| key_b | input | 1 | Key B line |
| unlock | output | 1 | One-cycle pulse that opens the door |
| press_count | output | 4 | Presses counted so far, for the LED decoder |

## Verification
The assertions take for granted that the three keypad lines change only between clock edges and hold a defined value at every rising edge. They place no limit on how long a key is held or which code appears. The bench changes the inputs only on the falling clock edge, so every code it applies is a clean synchronous value. It holds keys down for several cycles, applies codes with the key lines active but the flag low, and presses both keys at once, so the edge-detect and wrong-key properties are exercised without breaking that assumption.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    typedef enum logic [1:0] {
        KEY_A     = 2'd0,
        KEY_B     = 2'd1,
        KEY_WRONG = 2'd2
    } key_kind_e;

    // Meaningful only while the key-active flag is high.
    function automatic key_kind_e classify_key(input logic line_a, input logic line_b);
        if (line_a && !line_b) begin
            return KEY_A;
        end else if (line_b && !line_a) begin
            return KEY_B;
        end
        return KEY_WRONG;
    endfunction

endpackage

// File: rtl/keylock_keydec.sv
module keylock_keydec
    import keylock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      key_k,
    input  logic      key_a,
    input  logic      key_b,
    output logic      press_o,
    output key_kind_e kind_o
);

    typedef struct packed {
        logic k_seen;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d        = dec_q;
        dec_d.k_seen = key_k;
        press_o      = key_k && !dec_q.k_seen;
        kind_o       = classify_key(key_a, key_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    // R3: a held key cannot produce two presses in a row
    a_r3_single_press: assert property (@(posedge clk) disable iff (rst)
        press_o |=> !press_o);

    // R2: with the flag low no press is ever reported
    a_r2_no_key: assert property (@(posedge clk) disable iff (rst)
        !key_k |-> !press_o);

endmodule

// File: rtl/keylock_seq.sv
module keylock_seq
    import keylock_pkg::*;
#(
    parameter int                    PASS_LEN = 3,
    parameter logic [PASS_LEN-1:0]   PASS_SEQ = 3'b101,
    parameter int                    CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             press_i,
    input  key_kind_e        kind_i,
    output logic             unlock_o,
    output logic [CNT_W-1:0] count_o
);

    localparam int              DEP_W = $clog2(PASS_LEN + 1);
    localparam logic [DEP_W-1:0] LAST = DEP_W'(PASS_LEN);

    typedef struct packed {
        logic [DEP_W-1:0] depth;
        logic             bad;
    } seq_t;

    seq_t      seq_d, seq_q;
    logic      want_b;
    key_kind_e want_kind;

    always_comb begin
        want_b = 1'b0;
        for (int i = 0; i < PASS_LEN; i++) begin
            if (seq_q.depth == DEP_W'(i)) begin
                want_b = PASS_SEQ[i];
            end
        end
        want_kind = want_b ? KEY_B : KEY_A;
    end

    always_comb begin
        seq_d = seq_q;
        if (seq_q.depth == LAST) begin
            seq_d = '0;
        end else if (press_i) begin
            seq_d.depth = seq_q.depth + DEP_W'(1);
            if (kind_i != want_kind) begin
                seq_d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign unlock_o = (seq_q.depth == LAST) && !seq_q.bad;
    assign count_o  = CNT_W'(seq_q.depth);

    // R1: reset leaves count 0 and no unlock
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count_o == '0) && !unlock_o);

    // R3: without a press the state holds below full depth
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!press_i && seq_q.depth != LAST) |=> $stable(seq_q));

    // R4: an accepted press raises the count by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (press_i && seq_q.depth != LAST) |=> count_o == $past(count_o) + CNT_W'(1));

    // R6: a mismatched press puts the entry on the failed path
    a_r6_mismatch: assert property (@(posedge clk) disable iff (rst)
        (press_i && seq_q.depth != LAST && kind_i != want_kind) |=> seq_q.bad);

    // R7: full depth always returns to the start state
    a_r7_return: assert property (@(posedge clk) disable iff (rst)
        (seq_q.depth == LAST) |=> (count_o == '0) && !unlock_o);

    // R8: unlock is a single-cycle pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        unlock_o |=> !unlock_o);

endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
    import keylock_pkg::*;
#(
    parameter int                  PASS_LEN = 3,
    parameter logic [PASS_LEN-1:0] PASS_SEQ = 3'b101,
    parameter int                  CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_k,
    input  logic             key_a,
    input  logic             key_b,
    output logic             unlock,
    output logic [CNT_W-1:0] press_count
);

    logic      press_w;
    key_kind_e kind_w;

    keylock_keydec u_dec (
        .clk     (clk),
        .rst     (rst),
        .key_k   (key_k),
        .key_a   (key_a),
        .key_b   (key_b),
        .press_o (press_w),
        .kind_o  (kind_w)
    );

    keylock_seq #(
        .PASS_LEN (PASS_LEN),
        .PASS_SEQ (PASS_SEQ),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .press_i  (press_w),
        .kind_i   (kind_w),
        .unlock_o (unlock),
        .count_o  (press_count)
    );

endmodule

// File: tb/sim_keylock_ctrl.sv
module sim_keylock_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       key_k, key_a, key_b;
    logic       unlock;
    logic [3:0] press_count;

    int applied = 0;
    int miscompares = 0;
    int pulses = 0;
    bit done = 0;

    always #2 clk = ~clk;

    keylock_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .key_k       (key_k),
        .key_a       (key_a),
        .key_b       (key_b),
        .unlock      (unlock),
        .press_count (press_count)
    );

    // {k,a,b, expected unlock, expected count}
    localparam int NV = 41;
    localparam logic [7:0] VEC [NV] = '{
        8'b101_0_0001, 8'b000_0_0001, 8'b110_0_0010, 8'b110_0_0010, 8'b000_0_0010,
        8'b101_1_0011, 8'b000_0_0000, 8'b000_0_0000,
        8'b110_0_0001, 8'b000_0_0001, 8'b101_0_0010, 8'b000_0_0010, 8'b101_0_0011,
        8'b000_0_0000,
        8'b111_0_0001, 8'b000_0_0001, 8'b110_0_0010, 8'b000_0_0010, 8'b101_0_0011,
        8'b000_0_0000,
        8'b101_0_0001, 8'b000_0_0001, 8'b110_0_0010, 8'b000_0_0010, 8'b101_1_0011,
        8'b101_0_0000, 8'b101_0_0000, 8'b000_0_0000,
        8'b101_0_0001, 8'b000_0_0001, 8'b010_0_0001, 8'b100_0_0010, 8'b000_0_0010,
        8'b110_0_0011, 8'b000_0_0000,
        8'b101_0_0001, 8'b000_0_0001, 8'b110_0_0010, 8'b000_0_0010, 8'b110_0_0011,
        8'b000_0_0000
    };

    task automatic check(input string tag, input logic exp_u, input logic [3:0] exp_c);
        applied++;
        if (unlock !== exp_u || press_count !== exp_c) begin
            miscompares++;
            $display("FAIL %s: unlock=%b count=%0d, expected unlock=%b count=%0d",
                     tag, unlock, press_count, exp_u, exp_c);
        end
    endtask

    task automatic step(input logic [2:0] code);
        {key_k, key_a, key_b} = code;
        @(negedge clk);
        if (unlock === 1'b1) pulses++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        {key_k, key_a, key_b} = 3'b000;
        repeat (2) @(negedge clk);
        check("R1 reset state", 1'b0, 4'd0);
        rst = 1'b0;

        // table walk: R2 codes, R3 edges, R4 count, R5 unlock, R6 bad path, R7 return
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7:5]);
            check($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", i), VEC[i][4], VEC[i][3:0]);
        end

        // R8: two correct sequences in the table, one cycle each
        applied++;
        if (pulses != 2) begin
            miscompares++;
            $display("FAIL R8 pulse count: got %0d, expected 2", pulses);
        end

        // R1: reset in the middle of an entry
        step(3'b101); step(3'b000); step(3'b110);
        check("R4 before mid reset", 1'b0, 4'd2);
        rst = 1'b1;
        step(3'b000);
        check("R1 mid-entry reset", 1'b0, 4'd0);
        rst = 1'b0;
        step(3'b000);
        check("R1 after reset release", 1'b0, 4'd0);

        // R5: full correct entry after reset, long holds
        step(3'b101); step(3'b101); step(3'b101);
        check("R3 held B", 1'b0, 4'd1);
        step(3'b000); step(3'b110); step(3'b000); step(3'b000);
        check("R3 idle gaps", 1'b0, 4'd2);
        step(3'b101);
        check("R5 unlock after reset", 1'b1, 4'd3);
        step(3'b000);
        check("R7 return after unlock", 1'b0, 4'd0);

        // R6: repeated B at second position, then correct key still fails
        step(3'b101); step(3'b000); step(3'b101); step(3'b000); step(3'b101);
        check("R6 late correct key no unlock", 1'b0, 4'd3);
        step(3'b000);
        check("R7 return after fail", 1'b0, 4'd0);

        finish_run();
    end

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule